// File: doc/BRIEF.md
# Seed-Walking Stochastic Number Generator

This block turns a fixed-point fraction into a unipolar stochastic bit stream. On every clock it compares the input word with the state of a maximal-length LFSR of the same width. The output bit is high when the LFSR state is below the input, so over a full LFSR period the density of ones follows the fraction. Downstream stochastic arithmetic and counters consume the stream.

A plain converter replays the same pseudo-random sequence every period. In that case, feeding the same value twice gives the same bit pattern twice. Here the seed of each period comes from a seed register instead. When a period wraps, that register is incremented by one and loaded into the LFSR, so repeated conversions of one value never reuse a sequence. The increment skips zero so the LFSR cannot lock up.

The LFSR moves only on cycles where the step enable is high. A one-cycle strobe marks each completed period, so a decoding counter knows when a stream ends. After reset the block takes one load cycle to capture the caller's initial seed.

Top module: `sng_seedwalk`

## Requirements
- R1: While `rst_n` is low, `sbit` and `period_end` are 0. The first rising edge after release is a load cycle: the LFSR state and the period seed both take `init_seed`, no step is taken, and `sbit` stays 0 until that load has happened.
- R2: A zero initial seed is replaced by 1 when loaded. After arming, the LFSR state and the period seed are never zero.
- R3: Once loaded, `sbit` is 1 exactly when the current LFSR state, read as an unsigned number, is less than `value`. It follows `value` combinationally.
- R4: One step shifts the state left by one bit and feeds the XOR of the tap bits into bit 0. For W=16 the taps are bits 15, 14, 12 and 3. For W=8 they are bits 7, 5, 4 and 3.
- R5: The LFSR steps only on rising edges where `step_en` is 1. Otherwise the state is held and no period can end.
- R6: A period ends on the step whose successor would equal that period's seed, so every period is exactly 2^W-1 enabled steps.
- R7: On the step that ends a period, the seed becomes seed+1 (with the zero value skipped, so it wraps to 1). The LFSR loads that same new seed, and it starts the next period.
- R8: `period_end` is a registered pulse. It is high for exactly one cycle, in the cycle after the step that ended a period.
- R9: With `value` held at v and `step_en` held high for one whole period, the stream has exactly max(v-1, 0) ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en | input | 1 | Advance the LFSR on this edge |
| value | input | W | Unsigned fraction to encode |
| init_seed | input | W | Seed captured in the load cycle after reset |
| sbit | output | 1 | Stochastic output bit |
| period_end | output | 1 | One-cycle strobe after each completed period |

## Verification
A wrong tap or shift direction corrupts the state within a few enabled steps. It then shows on `sbit` as soon as a random threshold lands between the true and the wrong state, which takes a handful of cycles. A broken seed register or wrap detection shows up only at a period boundary, 2^W-1 enabled steps after arming. That is late as a strobe in the wrong cycle, as a wrong period length, or as a stream whose ones count misses max(v-1, 0). For this reason a 16-bit instance runs through one full period, and an 8-bit instance runs through hundreds of periods with held values.

// File: rtl/sng_pkg.sv
package sng_pkg;

  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_RUN  = 1'b1
  } sng_phase_e;

  // Feedback bit positions (bit i set = state bit i is tapped) of a
  // maximal-length left-shifting register, for widths 4 to 16.
  function automatic logic [15:0] sng_tap_mask(input int unsigned width);
    logic [15:0] m;
    case (width)
      4:       m = 16'h000C;
      5:       m = 16'h0014;
      6:       m = 16'h0030;
      7:       m = 16'h0060;
      8:       m = 16'h00B8;
      9:       m = 16'h0110;
      10:      m = 16'h0240;
      11:      m = 16'h0500;
      12:      m = 16'h0829;
      13:      m = 16'h100D;
      14:      m = 16'h2015;
      15:      m = 16'h6000;
      default: m = 16'hD008;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sng_lfsr_next.sv
module sng_lfsr_next
  import sng_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] next_o
);

  localparam logic [15:0]  TAP_ALL = sng_tap_mask(W);
  localparam logic [W-1:0] TAPS    = TAP_ALL[W-1:0];

  logic feedback;

  always_comb begin
    feedback = ^(state_i & TAPS);
    next_o   = {state_i[W-2:0], feedback};
  end

endmodule

// File: rtl/sng_seed_walker.sv
module sng_seed_walker
  import sng_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en_i,
  input  logic [W-1:0] init_seed_i,
  input  logic [W-1:0] lfsr_next_i,
  output logic [W-1:0] lfsr_o,
  output logic [W-1:0] seed_o,
  output logic         run_o,
  output logic         wrap_pulse_o
);

  localparam logic [W-1:0] ONE = W'(1);

  sng_phase_e  phase_q, phase_d;
  logic [W-1:0] lfsr_q, lfsr_d;
  logic [W-1:0] seed_q, seed_d;
  logic         pulse_q, pulse_d;
  logic         lfsr_ld, seed_ld;

  logic [W-1:0] init_fix;
  logic [W-1:0] seed_inc;
  logic [W-1:0] seed_succ;
  logic         period_done;

  // Seed arithmetic: zero never enters the register.
  always_comb begin
    init_fix  = (init_seed_i == '0) ? ONE : init_seed_i;
    seed_inc  = seed_q + ONE;
    seed_succ = (seed_inc == '0) ? ONE : seed_inc;
  end

  // Wrap detection against the seed that opened the current period.
  always_comb begin
    period_done = (phase_q == PH_RUN) && step_en_i && (lfsr_next_i == seed_q);
  end

  // Next-state logic.
  always_comb begin
    phase_d = phase_q;
    lfsr_d  = lfsr_q;
    seed_d  = seed_q;
    lfsr_ld = 1'b0;
    seed_ld = 1'b0;
    pulse_d = period_done;
    case (phase_q)
      PH_LOAD: begin
        phase_d = PH_RUN;
        lfsr_d  = init_fix;
        seed_d  = init_fix;
        lfsr_ld = 1'b1;
        seed_ld = 1'b1;
      end
      PH_RUN: begin
        if (step_en_i) begin
          lfsr_ld = 1'b1;
          if (period_done) begin
            seed_d  = seed_succ;
            lfsr_d  = seed_succ;
            seed_ld = 1'b1;
          end else begin
            lfsr_d  = lfsr_next_i;
          end
        end
      end
      default: phase_d = PH_LOAD;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '0;
    end else if (lfsr_ld) begin
      lfsr_q <= lfsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
    end else if (seed_ld) begin
      seed_q <= seed_d;
    end
  end

  assign lfsr_o       = lfsr_q;
  assign seed_o       = seed_q;
  assign run_o        = (phase_q == PH_RUN);
  assign wrap_pulse_o = pulse_q;

endmodule

// File: rtl/sng_threshold.sv
module sng_threshold #(
  parameter int unsigned W = 16
) (
  input  logic         run_i,
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] level_i,
  output logic         bit_o
);

  always_comb begin
    bit_o = run_i && (state_i < level_i);
  end

endmodule

// File: rtl/sng_seedwalk.sv
module sng_seedwalk #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic [W-1:0] value,
  input  logic [W-1:0] init_seed,
  output logic         sbit,
  output logic         period_end
);

  logic [W-1:0] lfsr_w;
  logic [W-1:0] nxt_w;
  logic [W-1:0] seed_w;
  logic         run_w;

  sng_lfsr_next #(.W(W)) u_next (
    .state_i (lfsr_w),
    .next_o  (nxt_w)
  );

  sng_seed_walker #(.W(W)) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en_i    (step_en),
    .init_seed_i  (init_seed),
    .lfsr_next_i  (nxt_w),
    .lfsr_o       (lfsr_w),
    .seed_o       (seed_w),
    .run_o        (run_w),
    .wrap_pulse_o (period_end)
  );

  sng_threshold #(.W(W)) u_cmp (
    .run_i   (run_w),
    .state_i (lfsr_w),
    .level_i (value),
    .bit_o   (sbit)
  );

endmodule

// File: rtl/sng_seedwalk_chk.sv
module sng_seedwalk_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_en,
  input logic         run,
  input logic [W-1:0] lfsr_q,
  input logic [W-1:0] seed_q,
  input logic         sbit,
  input logic         period_end
);

  a_r1_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!sbit && !period_end));

  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (lfsr_q != '0 && seed_q != '0));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step_en) |=> $stable(lfsr_q));

  a_r5_no_wrap_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step_en) |=> !period_end);

  a_r7_reseed_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (lfsr_q == seed_q));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);

endmodule

bind sng_seedwalk sng_seedwalk_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .run        (run_w),
  .lfsr_q     (lfsr_w),
  .seed_q     (seed_w),
  .sbit       (sbit),
  .period_end (period_end)
);

// File: tb/sng_seedwalk_bench.sv
`timescale 1ns/1ps
module sng_seedwalk_bench;

  localparam int N_CYC    = 76400;
  localparam int WD_LIMIT = 200000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        en0, en1;
  logic [15:0] val0, seedin0;
  logic [7:0]  val1, seedin1;
  logic        sb0, sb1, pe0, pe1;

  sng_seedwalk #(.W(16)) u_sng_seedwalk (
    .clk(clk), .rst_n(rst_n), .step_en(en0), .value(val0),
    .init_seed(seedin0), .sbit(sb0), .period_end(pe0));

  sng_seedwalk #(.W(8)) u_sng_seedwalk_w8 (
    .clk(clk), .rst_n(rst_n), .step_en(en1), .value(val1),
    .init_seed(seedin1), .sbit(sb1), .period_end(pe1));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_lfsr [2];
  logic [15:0] m_seed [2];
  logic        m_arm  [2];
  logic        m_pe   [2];
  int          steps  [2];
  bit          seen   [2];

  function automatic logic [15:0] wmask(input int i);
    return (i == 0) ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] fstep(input logic [15:0] s, input int i);
    logic fb;
    if (i == 0) fb = s[15] ^ s[14] ^ s[12] ^ s[3];
    else        fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return ((s << 1) | {15'd0, fb}) & wmask(i);
  endfunction

  function automatic logic [15:0] finc(input logic [15:0] s, input int i);
    logic [15:0] t;
    t = (s + 16'd1) & wmask(i);
    return (t == 16'd0) ? 16'd1 : t;
  endfunction

  function automatic logic [15:0] cur_val(input int i);
    return (i == 0) ? val0 : {8'd0, val1};
  endfunction

  function automatic logic cur_sb(input int i);
    return (i == 0) ? sb0 : sb1;
  endfunction

  function automatic logic cur_pe(input int i);
    return (i == 0) ? pe0 : pe1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clock(input int i);
    logic [15:0] n;
    logic [15:0] s;
    logic        en;
    en = (i == 0) ? en0 : en1;
    if (!rst_n) begin
      m_arm[i] = 1'b0; m_pe[i] = 1'b0; steps[i] = 0; seen[i] = 1'b0;
    end else if (!m_arm[i]) begin
      s = (i == 0) ? seedin0 : {8'd0, seedin1};
      if (s == 16'd0) s = 16'd1;
      m_lfsr[i] = s; m_seed[i] = s; m_arm[i] = 1'b1; m_pe[i] = 1'b0;
    end else if (en) begin
      n = fstep(m_lfsr[i], i);
      steps[i]++;
      if (n == m_seed[i]) begin
        m_seed[i] = finc(m_seed[i], i);
        m_lfsr[i] = m_seed[i];
        m_pe[i]   = 1'b1;
      end else begin
        m_lfsr[i] = n;
        m_pe[i]   = 1'b0;
      end
    end else begin
      m_pe[i] = 1'b0;
    end
  endtask

  initial begin
    #(WD_LIMIT * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit     counting;
    int     ones, exp_ones, k;
    logic [7:0] dv;
    logic   exp_sb;
    void'($urandom(32'h5EED_0001));
    rst_n = 1'b0; en0 = 1'b0; en1 = 1'b0; val0 = '0; val1 = '0;
    seedin0 = 16'hACE1; seedin1 = 8'h00;
    counting = 1'b0; ones = 0; exp_ones = 0; k = 0; dv = 8'h40;
    for (int i = 0; i < 2; i++) begin
      m_lfsr[i] = '0; m_seed[i] = '0; m_arm[i] = 1'b0; m_pe[i] = 1'b0;
      steps[i] = 0; seen[i] = 1'b0;
    end

    for (int c = 0; c < N_CYC; c++) begin
      @(negedge clk);
      // Compare outputs with the reference state.
      for (int i = 0; i < 2; i++) begin
        exp_sb = m_arm[i] && (m_lfsr[i] < cur_val(i));
        chk(cur_sb(i) == exp_sb, m_arm[i] ? "R3,R4,R5" : "R1", "sbit",
            cur_sb(i), exp_sb);
        chk(cur_pe(i) == m_pe[i], "R6,R7,R8", "period_end", cur_pe(i), m_pe[i]);
        if (m_pe[i]) begin
          if (seen[i]) chk(steps[i] == int'(wmask(i)), "R6", "period length",
                           steps[i], wmask(i));
          seen[i] = 1'b1; steps[i] = 0;
        end
      end
      // Directed load checks.
      if (c == 6) begin
        chk(sb0 == 1'b1, "R1", "sbit after load (seed ACE1 < ACE2)", sb0, 1);
        chk(sb1 == 1'b1, "R2", "zero seed loads 1 (1 < 2)", sb1, 1);
      end
      if (c == 7) chk(sb0 == 1'b0, "R1", "sbit after load (seed ACE1 vs ACE1)", sb0, 0);
      // Density window bookkeeping for the 8-bit instance.
      if (m_pe[1] && c >= 2000 && rst_n) begin
        if (counting) chk(ones == exp_ones, "R9", "ones per period", ones, exp_ones);
        case (k % 6)
          0: dv = 8'h40;
          1: dv = 8'h00;
          2: dv = 8'hFF;
          3: dv = 8'h01;
          4: dv = 8'h80;
          default: dv = 8'($urandom);
        endcase
        k++;
        counting = 1'b1; ones = 0;
        exp_ones = (dv == 8'd0) ? 0 : int'(dv) - 1;
      end
      // Drive inputs.
      if (c < 5) rst_n = 1'b0;
      else if (c >= 76000 && c < 76003) begin
        rst_n = 1'b0; seedin0 = 16'hFFFF; seedin1 = 8'h01;
      end else rst_n = 1'b1;

      if (c == 5) begin en0 = 1'b0; val0 = 16'hACE2; end
      else if (c == 6) begin en0 = 1'b0; val0 = 16'hACE1; end
      else if (c > 6) begin
        en0 = (($urandom % 16) != 0);
        case ($urandom % 8)
          0: val0 = 16'h0000;
          1: val0 = 16'hFFFF;
          default: val0 = 16'($urandom);
        endcase
      end

      if (c == 5) begin en1 = 1'b0; val1 = 8'd2; end
      else if (c > 5 && c < 2000) begin
        en1 = (($urandom % 4) != 0);
        val1 = 8'($urandom);
      end else if (c >= 2000) begin
        en1 = 1'b1; val1 = dv;
      end

      if (!rst_n) counting = 1'b0;
      #1;
      if (counting) ones += int'(sb1);
      model_clock(0);
      model_clock(1);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule